// File: doc/BRIEF.md
# Addressed Serial Control Register

This block receives control frames over a three-wire serial link made of a data line, a shift clock and an active-low enable. All three lines are asynchronous to the system clock, so each is passed through a synchronizer before its edges are detected. While the enable is low, every rising edge of the shift clock appends one data bit to a frame register and advances a bit counter. When the enable returns high, the frame is checked. The frame is committed only if it holds exactly 22 bits and its first two bits equal the device address strapped on an input. Requiring an address match lets several receivers share the same three wires.

A committed frame loads three outputs at once: a 14-bit divide code, six function outputs, and a band flag that mirrors one of the six function bits. A one-cycle load strobe marks the update. The function outputs are plain logic levels. Any pin drivers sit outside this block.

Top module: `synth_ctrl_port`

## Requirements
- R1: Shift-clock rising edges that arrive while the enable is high change neither the frame nor the bit count. After such edges, no output changes and no load strobe occurs.
- R2: Outputs change only after a low-to-high transition of the enable. A full, matching frame that is still being held with the enable low leaves the outputs at their previous values.
- R3: Data is sampled on the rising edge of the shift clock. Frame bits are numbered 1 to 22 in arrival order.
- R4: Frame bits 1 and 2 form the address, with bit 1 as the MSB. When the address differs from `dev_addr_i`, the outputs keep their values and no load strobe occurs.
- R5: The bit count at the enable rising edge must be exactly 22. With 21 bits or 23 bits, the outputs keep their values and no load strobe occurs.
- R6: Frame bits 3 to 16 load `div_code_o`, with bit 3 as the MSB.
- R7: Frame bit 17+k loads `func_o[k]` for k from 0 to 5.
- R8: `band_fm_o` equals frame bit 20, which is also `func_o[3]`. A value of 1 selects FM and 0 selects AM.
- R9: `load_pulse_o` is high for exactly one system clock per accepted frame, in the same cycle that the new values first appear on the outputs.
- R10: After reset, all outputs are zero, which means AM with a divide code of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_addr_i | input | 2 | Address this receiver answers to |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_en_ni | input | 1 | Enable; shifting while low, commit on rise |
| div_code_o | output | 14 | Latched divide code |
| func_o | output | 6 | Latched function outputs |
| band_fm_o | output | 1 | Band select, 1 = FM |
| load_pulse_o | output | 1 | One-cycle strobe on each accepted frame |

## Verification
The bench uses the default widths (2-bit address, 14-bit code, 6 function bits) and the default two synchronizer stages, with the device address strapped to 2'b10. With these defaults, frame lengths one bit short of and one bit past 22 can be exercised directly. The bench also drives a wrong address and sends stray shift-clock edges while the enable is high. It uses code and function patterns that toggle the band bit both ways and reach the all-ones and single-bit extremes of the code.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;

    localparam int unsigned ADDR_W_DEF   = 2;
    localparam int unsigned CODE_W_DEF   = 14;
    localparam int unsigned FUNC_W_DEF   = 6;
    localparam int unsigned BAND_POS_DEF = 3;
    localparam int unsigned SYNC_DEF     = 2;

    typedef enum logic {
        BAND_AM = 1'b0,
        BAND_FM = 1'b1
    } band_e;

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sc_edge.sv
module sc_edge #(
    parameter bit RISING = 1'b1,
    parameter bit INIT   = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic edge_o
);

    logic prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= INIT;
        else         prev_q <= prev_d;
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = level_i & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~level_i & prev_q;
        end
    endgenerate

endmodule

// File: rtl/sc_frame_shifter.sv
module sc_frame_shifter #(
    parameter int unsigned FRAME_W = 22,
    localparam int unsigned CNT_W  = $clog2(FRAME_W + 2)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sdata_i,
    input  logic               sclk_rise_i,
    input  logic               en_low_i,
    input  logic               en_fall_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   count_o
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        logic [CNT_W-1:0] base;
        st_d = st_q;
        base = en_fall_i ? '0 : st_q.cnt;
        st_d.cnt = base;
        if (sclk_rise_i && en_low_i) begin
            st_d.sr  = {st_q.sr[FRAME_W-2:0], sdata_i};
            st_d.cnt = (base == CNT_SAT) ? base : base + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign frame_o = st_q.sr;
    assign count_o = st_q.cnt;

    // R1: nothing moves while the enable is high
    a_r1_frozen_when_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_low_i |=> ($stable(st_q.sr) && $stable(st_q.cnt)));

    // R5: counter never exceeds its saturation point
    a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == CNT_SAT) && !en_fall_i |=> (st_q.cnt == CNT_SAT));

endmodule

// File: rtl/sc_word_latch.sv
module sc_word_latch
    import synth_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADDR_W_DEF,
    parameter int unsigned CODE_W   = CODE_W_DEF,
    parameter int unsigned FUNC_W   = FUNC_W_DEF,
    parameter int unsigned BAND_POS = BAND_POS_DEF,
    localparam int unsigned FRAME_W = ADDR_W + CODE_W + FUNC_W,
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_rise_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [ADDR_W-1:0]  dev_addr_i,
    output logic [CODE_W-1:0]  code_o,
    output logic [FUNC_W-1:0]  func_o,
    output band_e              band_o,
    output logic               load_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [FUNC_W-1:0] func;
        logic              load;
    } latch_t;

    latch_t st_d, st_q;

    logic [ADDR_W-1:0] frame_addr;
    logic [CODE_W-1:0] frame_code;
    logic [FUNC_W-1:0] frame_func;
    logic              commit;

    assign frame_addr = frame_i[FRAME_W-1 -: ADDR_W];
    assign frame_code = frame_i[FUNC_W +: CODE_W];

    // earliest-arriving function bit maps to index 0
    generate
        for (genvar k = 0; k < FUNC_W; k++) begin : g_func_map
            assign frame_func[k] = frame_i[FUNC_W-1-k];
        end
    endgenerate

    assign commit = en_rise_i && (count_i == CNT_W'(FRAME_W)) && (frame_addr == dev_addr_i);

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (commit) begin
            st_d.code = frame_code;
            st_d.func = frame_func;
            st_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign func_o = st_q.func;
    assign band_o = band_e'(st_q.func[BAND_POS]);
    assign load_o = st_q.load;

    // R9: strobe lasts a single cycle
    a_r9_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.load |=> !st_q.load);

    // R2: a load always follows an enable rising edge
    a_r2_load_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.load |-> $past(en_rise_i));

    // R5: a load only follows a full-length frame
    a_r5_load_full_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.load |-> ($past(count_i) == CNT_W'(FRAME_W)));

    // R4: outputs hold between loads
    a_r4_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.load |-> ($stable(st_q.code) && $stable(st_q.func)));

endmodule

// File: rtl/synth_ctrl_port.sv
module synth_ctrl_port
    import synth_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W      = ADDR_W_DEF,
    parameter int unsigned CODE_W      = CODE_W_DEF,
    parameter int unsigned FUNC_W      = FUNC_W_DEF,
    parameter int unsigned BAND_POS    = BAND_POS_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF,
    localparam int unsigned FRAME_W    = ADDR_W + CODE_W + FUNC_W,
    localparam int unsigned CNT_W      = $clog2(FRAME_W + 2)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic              ser_data_i,
    input  logic              ser_clk_i,
    input  logic              ser_en_ni,
    output logic [CODE_W-1:0] div_code_o,
    output logic [FUNC_W-1:0] func_o,
    output logic              band_fm_o,
    output logic              load_pulse_o
);

    localparam int unsigned IDX_DATA = 0;
    localparam int unsigned IDX_CLK  = 1;
    localparam int unsigned IDX_EN   = 2;

    logic [2:0]         raw_lines, sync_lines;
    logic               sclk_rise, en_rise, en_fall;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   count;
    band_e              band;

    assign raw_lines = {ser_en_ni, ser_clk_i, ser_data_i};

    sc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_lines),
        .sync_o  (sync_lines)
    );

    sc_edge #(.RISING(1'b1), .INIT(1'b0)) u_sclk_rise (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (sync_lines[IDX_CLK]),
        .edge_o  (sclk_rise)
    );

    sc_edge #(.RISING(1'b1), .INIT(1'b0)) u_en_rise (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (sync_lines[IDX_EN]),
        .edge_o  (en_rise)
    );

    sc_edge #(.RISING(1'b0), .INIT(1'b0)) u_en_fall (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (sync_lines[IDX_EN]),
        .edge_o  (en_fall)
    );

    sc_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sdata_i     (sync_lines[IDX_DATA]),
        .sclk_rise_i (sclk_rise),
        .en_low_i    (~sync_lines[IDX_EN]),
        .en_fall_i   (en_fall),
        .frame_o     (frame),
        .count_o     (count)
    );

    sc_word_latch #(
        .ADDR_W   (ADDR_W),
        .CODE_W   (CODE_W),
        .FUNC_W   (FUNC_W),
        .BAND_POS (BAND_POS)
    ) u_latch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_rise_i  (en_rise),
        .frame_i    (frame),
        .count_i    (count),
        .dev_addr_i (dev_addr_i),
        .code_o     (div_code_o),
        .func_o     (func_o),
        .band_o     (band),
        .load_o     (load_pulse_o)
    );

    assign band_fm_o = (band == BAND_FM);

    // R8: band flag agrees with the function bit it shares
    a_r8_band_matches_func: assert property (@(posedge clk_i) disable iff (!rst_ni)
        band_fm_o == func_o[BAND_POS]);

endmodule

// File: tb/synth_ctrl_port_tb.sv
module synth_ctrl_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] MY_ADDR = 2'b10;

    typedef struct {
        logic [13:0] code;
        logic [5:0]  func;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdata = 1'b0;
    logic        sclk = 1'b0;
    logic        sen_n = 1'b1;
    logic [13:0] div_code;
    logic [5:0]  func;
    logic        band_fm;
    logic        load_pulse;

    int checks = 0;
    int errors = 0;
    int loads_seen = 0;
    int loads_exp = 0;
    bit finished = 1'b0;
    bit prev_load = 1'b0;
    exp_t sb_q[$];
    logic [13:0] last_code = '0;
    logic [5:0]  last_func = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_ctrl_port u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .dev_addr_i   (MY_ADDR),
        .ser_data_i   (sdata),
        .ser_clk_i    (sclk),
        .ser_en_ni    (sen_n),
        .div_code_o   (div_code),
        .func_o       (func),
        .band_fm_o    (band_fm),
        .load_pulse_o (load_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(prev_load && load_pulse), "R9 strobe width", 32'(load_pulse), 32'd0);
            if (load_pulse) begin
                loads_seen++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4/R5 unexpected load", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(div_code == e.code, "R6 divide code", 32'(div_code), 32'(e.code));
                    check(func == e.func, "R7 function outputs", 32'(func), 32'(e.func));
                    check(band_fm == e.func[3], "R8 band select", 32'(band_fm), 32'(e.func[3]));
                end
            end
            prev_load = load_pulse;
        end
    end

    task automatic shift_bit(input logic b);
        @(negedge clk);
        sdata = b;
        sclk  = 1'b0;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    // driver: sends nbits from the frame head; extra bits beyond 22 are zeros
    task automatic send_frame(input logic [1:0] addr, input logic [13:0] code,
                              input logic [5:0] fn, input int nbits, input bit accept);
        logic [21:0] f;
        logic [5:0]  rev;
        for (int k = 0; k < 6; k++) rev[5-k] = fn[k];
        f = {addr, code, rev};
        @(negedge clk);
        sen_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            shift_bit(i < 22 ? f[21-i] : 1'b0);
        end
        repeat (6) @(negedge clk);
        // R2: still held low, nothing may have changed
        check(div_code == last_code && func == last_func, "R2 no change before enable rise",
              32'({div_code, func}), 32'({last_code, last_func}));
        if (accept) begin
            exp_t e;
            e.code = code;
            e.func = fn;
            sb_q.push_back(e);
            loads_exp++;
            last_code = code;
            last_func = fn;
        end
        sen_n = 1'b1;
        repeat (12) @(negedge clk);
        check(loads_seen == loads_exp, "R4/R5 load count", 32'(loads_seen), 32'(loads_exp));
        check(div_code == last_code && func == last_func, "R3 outputs after frame",
              32'({div_code, func}), 32'({last_code, last_func}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(div_code == 14'd0, "R10 reset code", 32'(div_code), 32'd0);
        check(func == 6'd0, "R10 reset func", 32'(func), 32'd0);
        check(band_fm == 1'b0, "R10 reset band AM", 32'(band_fm), 32'd0);
        check(load_pulse == 1'b0, "R10 reset strobe", 32'(load_pulse), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3/R6/R7/R8: accepted frames, band toggled both ways
        send_frame(MY_ADDR, 14'h2A5B, 6'b001011, 22, 1'b1);
        send_frame(MY_ADDR, 14'h3FFF, 6'b111111, 22, 1'b1);
        send_frame(MY_ADDR, 14'h0001, 6'b110100, 22, 1'b1);
        check(band_fm == 1'b0, "R8 AM after bit cleared", 32'(band_fm), 32'd0);

        // R4: wrong address
        send_frame(2'b01, 14'h1234, 6'b101010, 22, 1'b0);
        // R5: short and long frames
        send_frame(MY_ADDR, 14'h0F0F, 6'b011110, 21, 1'b0);
        send_frame(MY_ADDR, 14'h0F0F, 6'b011110, 23, 1'b0);

        // R1: shift clock activity with the enable high
        for (int i = 0; i < 22; i++) shift_bit(i[0]);
        repeat (10) @(negedge clk);
        check(loads_seen == loads_exp, "R1 no load from clocks while high",
              32'(loads_seen), 32'(loads_exp));
        check(div_code == last_code && func == last_func, "R1 outputs unchanged",
              32'({div_code, func}), 32'({last_code, last_func}));

        // recovery after rejects
        send_frame(MY_ADDR, 14'h2000, 6'b001000, 22, 1'b1);
        check(band_fm == 1'b1, "R8 FM selected", 32'(band_fm), 32'd1);
        check(sb_q.size() == 0, "R9 every expected load seen", 32'(sb_q.size()), 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule